// File: doc/BRIEF.md
# Cascadable Bypass Magnitude Comparator

This block compares two unsigned operands of equal width and reports whether the first is greater than, equal to, or less than the second. It is purely combinational. The operands are cut into identical slices of a fixed width, and the slices are chained from the least significant end to the most significant end.

Each slice first compares its own bits. This local compare gives four signals: strictly greater, strictly less, greater-or-equal and less-or-equal. The slice then merges this local result with the running three-flag verdict that arrives from the slice below, and passes on an updated verdict. The top slice's verdict is the block's output, so no separate final combining stage exists. The propagate terms are greater-or-equal and less-or-equal, not strict equality. A verdict from below therefore passes through a slice even when that slice has already settled the outcome. In that case the local term still wins, so the result is unchanged.

The worst path is one slice-wide local compare followed by one merge step for each of the remaining slices. A parameter selects the slice width. Use this block where a full ripple compare is too slow but a tree or a parallel compare is too costly in area.

Top module: `bypass_mag_cmp`

## Requirements
- R1: `cmp_gt` is 1 exactly when `op_a` is greater than `op_b` as an unsigned number.
- R2: `cmp_lt` is 1 exactly when `op_a` is less than `op_b` as an unsigned number.
- R3: `cmp_eq` is 1 exactly when `op_a` and `op_b` are bit-for-bit equal.
- R4: Exactly one of `cmp_gt`, `cmp_eq`, `cmp_lt` is 1 for any known pair of operands.
- R5: When the most significant differing bit lies in an upper slice, the bits of all lower slices have no effect on the outputs.
- R6: The verdict fed into the lowest slice is fixed at "equal". As a result, operands that differ only in bit 0 are still decided correctly, and fully equal operands give `cmp_eq`.
- R7: The outputs depend only on the present operands: no clock or state is involved. A new operand pair gives its verdict within the same cycle it is applied.
- R8: The extreme operands are handled correctly: all-zeros against all-ones, all-ones against all-ones, and all-zeros against all-zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| cmp_gt | output | 1 | op_a greater than op_b |
| cmp_eq | output | 1 | op_a equal to op_b |
| cmp_lt | output | 1 | op_a less than op_b |

## Verification
The assertions assume that both operands are two-valued. They skip any evaluation in which an operand bit is unknown, because the one-hot property has no meaning for an undriven input. The bench drives both operands to known values from time zero. It changes them only on the falling clock edge, and it samples the three flags on the rising edge, once the combinational chain has settled. The stimulus is built so that the deciding bit falls in every slice position, including the lowest and highest bits. It also perturbs lower slices beneath an already decided upper slice.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // Running three-flag verdict passed between slices (one-hot).
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    // Local result of a single slice compare.
    typedef struct packed {
        logic gt;   // slice strictly greater
        logic lt;   // slice strictly less
        logic ge;   // slice greater or equal (propagates a greater verdict)
        logic le;   // slice less or equal (propagates a less verdict)
    } slice_t;

    localparam rel_t REL_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

    // Bypass merge: the local decision wins; otherwise the lower verdict passes.
    function automatic rel_t merge_rel(input slice_t loc, input rel_t lower);
        rel_t r;
        r.gt = loc.gt | (loc.ge & lower.gt);
        r.lt = loc.lt | (loc.le & lower.lt);
        r.eq = loc.ge & loc.le & lower.eq;
        return r;
    endfunction

endpackage

// File: rtl/cmp_slice_local.sv
module cmp_slice_local
    import cmp_pkg::*;
#(
    parameter int SLICE = 2
) (
    input  logic [SLICE-1:0] sa,
    input  logic [SLICE-1:0] sb,
    output slice_t           res
);
    logic gt_w;
    logic lt_w;
    logic same_w;

    // Scan from the top bit down; the first differing bit decides.
    always_comb begin
        gt_w = 1'b0;
        lt_w = 1'b0;
        for (int i = SLICE - 1; i >= 0; i--) begin
            if (!gt_w && !lt_w) begin
                if (sa[i] && !sb[i]) begin
                    gt_w = 1'b1;
                end else if (!sa[i] && sb[i]) begin
                    lt_w = 1'b1;
                end
            end
        end
    end

    assign same_w = (sa == sb);

    always_comb begin
        res.gt = gt_w;
        res.lt = lt_w;
        res.ge = same_w | gt_w;
        res.le = same_w | lt_w;
    end
endmodule

// File: rtl/cmp_slice_merge.sv
module cmp_slice_merge
    import cmp_pkg::*;
(
    input  slice_t loc,
    input  rel_t   rel_in,
    output rel_t   rel_out
);
    assign rel_out = merge_rel(loc, rel_in);
endmodule

// File: rtl/cmp_bypass_stage.sv
module cmp_bypass_stage
    import cmp_pkg::*;
#(
    parameter int SLICE = 2
) (
    input  logic [SLICE-1:0] sa,
    input  logic [SLICE-1:0] sb,
    input  rel_t             rel_in,
    output rel_t             rel_out
);
    slice_t loc;

    cmp_slice_local #(.SLICE(SLICE)) u_local (
        .sa  (sa),
        .sb  (sb),
        .res (loc)
    );

    cmp_slice_merge u_merge (
        .loc     (loc),
        .rel_in  (rel_in),
        .rel_out (rel_out)
    );
endmodule

// File: rtl/bypass_mag_cmp.sv
module bypass_mag_cmp
    import cmp_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int SLICE = 2
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             cmp_gt,
    output logic             cmp_eq,
    output logic             cmp_lt
);
    localparam int STAGES = WIDTH / SLICE;

    generate
        if ((WIDTH % SLICE) != 0 || SLICE < 1) begin : g_bad_cfg
            $error("WIDTH must be a positive multiple of SLICE");
        end
    endgenerate

    rel_t chain [0:STAGES];

    // R6: the lowest slice sees a fixed "equal" verdict.
    assign chain[0] = REL_EQUAL;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            cmp_bypass_stage #(.SLICE(SLICE)) u_stage (
                .sa      (op_a[s*SLICE +: SLICE]),
                .sb      (op_b[s*SLICE +: SLICE]),
                .rel_in  (chain[s]),
                .rel_out (chain[s+1])
            );
        end
    endgenerate

    assign cmp_gt = chain[STAGES].gt;
    assign cmp_eq = chain[STAGES].eq;
    assign cmp_lt = chain[STAGES].lt;
endmodule

// File: rtl/bypass_mag_cmp_chk.sv
module bypass_mag_cmp_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             cmp_gt,
    input logic             cmp_eq,
    input logic             cmp_lt
);
    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            a_r4_onehot: assert ($onehot({cmp_gt, cmp_eq, cmp_lt}))
                else $error("R4 verdict not one-hot");
            a_r1_greater: assert (cmp_gt == (op_a > op_b))
                else $error("R1 greater flag wrong");
            a_r2_less: assert (cmp_lt == (op_a < op_b))
                else $error("R2 less flag wrong");
            a_r3_equal: assert (cmp_eq == (op_a == op_b))
                else $error("R3 equal flag wrong");
        end
    end
endmodule

bind bypass_mag_cmp bypass_mag_cmp_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a   (op_a),
    .op_b   (op_b),
    .cmp_gt (cmp_gt),
    .cmp_eq (cmp_eq),
    .cmp_lt (cmp_lt)
);

// File: tb/test_bypass_mag_cmp.sv
module test_bypass_mag_cmp;
    localparam int W = 16;
    localparam int SL = 2;

    typedef struct {
        logic  gt;
        logic  eq;
        logic  lt;
        string req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         cmp_gt, cmp_eq, cmp_lt;

    int   n_checks = 0;
    int   n_errors = 0;
    int   cycles = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    bypass_mag_cmp #(.WIDTH(W), .SLICE(SL)) i_bypass_mag_cmp (
        .op_a   (op_a),
        .op_b   (op_b),
        .cmp_gt (cmp_gt),
        .cmp_eq (cmp_eq),
        .cmp_lt (cmp_lt)
    );

    // Driver: apply a pair on the falling edge and queue the expected verdict.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        exp_t e;
        @(negedge clk);
        op_a = a;
        op_b = b;
        e.gt = (a > b);
        e.eq = (a == b);
        e.lt = (a < b);
        e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: the verdict is combinational, so it is sampled on the next rising edge.
    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if ({cmp_gt, cmp_eq, cmp_lt} !== {e.gt, e.eq, e.lt}) begin
                n_errors++;
                $display("FAIL %s a=%h b=%h got gt/eq/lt=%b%b%b expected %b%b%b",
                         e.req, op_a, op_b, cmp_gt, cmp_eq, cmp_lt, e.gt, e.eq, e.lt);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_errors++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // Reset state: both operands zero give equal (R3, R8)
        drive('0, '0, "R3_R8_zero_zero");
        drive('1, '1, "R8_ones_ones");
        drive('0, '1, "R8_zero_ones");
        drive('1, '0, "R8_ones_zero");
        // R6: differ only in bit 0
        drive(16'h0001, 16'h0000, "R6_bit0_gt");
        drive(16'h1234, 16'h1235, "R6_bit0_lt");
        drive(16'hBEEF, 16'hBEEF, "R3_equal");
        // Deciding bit at every position (R1, R2)
        for (int i = 0; i < W; i++) begin
            drive(W'(1) << i, '0, "R1_single_bit");
            drive(16'h5555 & ~(W'(1) << i), 16'h5555 | (W'(1) << i), "R2_single_bit");
        end
        // R5: upper slice decides, lower slices varied
        for (int s = 1; s < W / SL; s++) begin
            for (int k = 0; k < 6; k++) begin
                logic [W-1:0] lo_a, lo_b, a, b;
                lo_a = W'($urandom) & ((W'(1) << (s * SL)) - 1);
                lo_b = W'($urandom) & ((W'(1) << (s * SL)) - 1);
                a = (W'(1) << (s * SL)) | lo_a;
                b = lo_b;
                drive(a, b, "R5_upper_gt");
                drive(b, a, "R5_upper_lt");
            end
        end
        // R7: back-to-back pairs, each sampled in its own cycle
        drive(16'h8000, 16'h7FFF, "R7_fast_gt");
        drive(16'h7FFF, 16'h8000, "R7_fast_lt");
        drive(16'h7FFF, 16'h7FFF, "R7_fast_eq");
        // Random pairs (R1, R2, R3, R4)
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = (k % 4 == 0) ? a : W'($urandom);
            drive(a, b, "R1_R2_R3_R4_random");
        end
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule